// File: doc/BRIEF.md
# Load-to-Store Write-Data Bypass

This block sits in the memory stage of a five-stage integer pipeline, in front of the write-data port of the data memory. When a load is directly followed by a store whose data register is the one the load is filling, the loaded word appears only at the end of the load's memory cycle. The store needs that word at the start of its own memory cycle, one cycle later. The block sends the word held in the memory/writeback register straight to the write port, so the store does not stall.

The decision looks at the instruction now in the memory stage and the one in writeback. The store's data-register number and store flag come from the execute/memory pipeline register. The writeback side supplies its destination number, its register-write flag and its memory-to-register flag. A select of type `wd_src_e` chooses between two named sources. `WD_FROM_PIPE` passes the normal pipelined store data. `WD_FROM_LOAD` passes the writeback-stage load word.

There is no sequential state and there are no transitions. The select is a pure function of the current inputs, and the output changes in the same cycle as the inputs. Other dependencies are not handled here. A store whose base or data register was written by an ALU instruction one cycle earlier is resolved by execute-stage forwarding before the store reaches this point.

Top module: `ldst_bypass`

## Requirements
- R1: When `em_is_store`=1, `mw_reg_write`=1, `mw_mem_to_reg`=1, `mw_dest` is nonzero and `mw_dest` equals `em_store_src`, `wr_data` equals `mw_load_data`.
- R2: When `mw_dest` is 0 (register zero is hardwired), `wr_data` equals `em_store_data` whatever the other inputs are.
- R3: When `em_is_store`=0, `wr_data` equals `em_store_data` even if the register numbers match.
- R4: When `mw_mem_to_reg`=0 (the writeback instruction is not a load), `wr_data` equals `em_store_data`.
- R5: When `mw_reg_write`=0, `wr_data` equals `em_store_data`.
- R6: When `mw_dest` differs from `em_store_src`, `wr_data` equals `em_store_data`.
- R7: The path is combinational. `wr_data` reflects the inputs applied in the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| em_is_store | input | 1 | Memory-stage instruction is a store |
| em_store_src | input | REG_AW | Store's data-register number |
| em_store_data | input | DATA_W | Pipelined store data |
| mw_reg_write | input | 1 | Writeback instruction writes a register |
| mw_mem_to_reg | input | 1 | Writeback value comes from memory (load) |
| mw_dest | input | REG_AW | Writeback destination register number |
| mw_load_data | input | DATA_W | Word loaded by the writeback instruction |
| wr_data | output | DATA_W | Data for the data-memory write port |

## Verification
The bench builds the block with `DATA_W`=16 and `REG_AW`=3. With these values every combination of the three flags and the two register numbers can be swept, 512 cases in all. This covers register zero, matching and non-matching numbers, and each flag that blocks the bypass on its own. In every case the store word and the load word differ, so a wrong source choice always shows at `wr_data`.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
    typedef enum logic {
        WD_FROM_PIPE = 1'b0,
        WD_FROM_LOAD = 1'b1
    } wd_src_e;
endpackage

// File: rtl/ldst_match.sv
module ldst_match
    import bypass_pkg::*;
#(
    parameter int REG_AW    = 5,
    parameter bit ZERO_HARD = 1'b1
) (
    input  logic              is_store,
    input  logic [REG_AW-1:0] store_src,
    input  logic              wb_reg_write,
    input  logic              wb_mem_to_reg,
    input  logic [REG_AW-1:0] wb_dest,
    output wd_src_e           src_sel
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic dest_live;
    logic hit;

    generate
        if (ZERO_HARD) begin : g_zero_guard
            assign dest_live = (wb_dest != ZERO_REG);
        end else begin : g_no_guard
            assign dest_live = 1'b1;
        end
    endgenerate

    always_comb begin
        hit = is_store && wb_reg_write && wb_mem_to_reg && dest_live
              && (wb_dest == store_src);
        src_sel = hit ? WD_FROM_LOAD : WD_FROM_PIPE;
    end
endmodule

// File: rtl/wd_mux.sv
module wd_mux
    import bypass_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  wd_src_e           sel,
    input  logic [DATA_W-1:0] pipe_data,
    input  logic [DATA_W-1:0] load_data,
    output logic [DATA_W-1:0] out_data
);
    always_comb begin
        unique case (sel)
            WD_FROM_PIPE: out_data = pipe_data;
            WD_FROM_LOAD: out_data = load_data;
            default:      out_data = pipe_data;
        endcase
    end
endmodule

// File: rtl/ldst_bypass.sv
module ldst_bypass
    import bypass_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_AW = 5
) (
    input  logic              em_is_store,
    input  logic [REG_AW-1:0] em_store_src,
    input  logic [DATA_W-1:0] em_store_data,
    input  logic              mw_reg_write,
    input  logic              mw_mem_to_reg,
    input  logic [REG_AW-1:0] mw_dest,
    input  logic [DATA_W-1:0] mw_load_data,
    output logic [DATA_W-1:0] wr_data
);
    wd_src_e fwd_sel;

    ldst_match #(.REG_AW(REG_AW), .ZERO_HARD(1'b1)) match_i (
        .is_store      (em_is_store),
        .store_src     (em_store_src),
        .wb_reg_write  (mw_reg_write),
        .wb_mem_to_reg (mw_mem_to_reg),
        .wb_dest       (mw_dest),
        .src_sel       (fwd_sel)
    );

    wd_mux #(.DATA_W(DATA_W)) mux_i (
        .sel       (fwd_sel),
        .pipe_data (em_store_data),
        .load_data (mw_load_data),
        .out_data  (wr_data)
    );

    always_comb begin
        if (!$isunknown({em_is_store, em_store_src, em_store_data, mw_reg_write,
                         mw_mem_to_reg, mw_dest, mw_load_data})) begin
            if (em_is_store && mw_reg_write && mw_mem_to_reg &&
                mw_dest != '0 && mw_dest == em_store_src)
                a_r1_load_word_used: assert (wr_data == mw_load_data);
            if (mw_dest == '0)
                a_r2_zero_reg_never_bypassed: assert (wr_data == em_store_data);
            if (!em_is_store)
                a_r3_non_store_passes: assert (wr_data == em_store_data);
            if (!mw_mem_to_reg)
                a_r4_alu_result_not_bypassed: assert (wr_data == em_store_data);
            if (!mw_reg_write)
                a_r5_no_write_no_bypass: assert (wr_data == em_store_data);
            if (mw_dest != em_store_src)
                a_r6_mismatch_passes: assert (wr_data == em_store_data);
        end
    end
endmodule

// File: tb/ldst_bypass_tb_top.sv
module ldst_bypass_tb_top;
    localparam int  DW       = 16;
    localparam int  AW       = 3;
    localparam time CLK_PER  = 10;
    localparam int  WD_LIMIT = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          is_st;
    logic [AW-1:0] st_src;
    logic [DW-1:0] st_data;
    logic          rw;
    logic          m2r;
    logic [AW-1:0] dst;
    logic [DW-1:0] ld_data;
    logic [DW-1:0] wd;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    ldst_bypass #(.DATA_W(DW), .REG_AW(AW)) dut_i (
        .em_is_store   (is_st),
        .em_store_src  (st_src),
        .em_store_data (st_data),
        .mw_reg_write  (rw),
        .mw_mem_to_reg (m2r),
        .mw_dest       (dst),
        .mw_load_data  (ld_data),
        .wr_data       (wd)
    );

    task automatic check(input string req, input logic [DW-1:0] exp);
        n_cmp++;
        if (wd !== exp) begin
            n_bad++;
            $display("FAIL %s: wr_data=%h expected=%h (st=%0b rw=%0b m2r=%0b src=%0d dst=%0d)",
                     req, wd, exp, is_st, rw, m2r, st_src, dst);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT && !done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: cycles=%0d expected=<%0d", cyc, WD_LIMIT);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        is_st = 0; st_src = 0; st_data = '0; rw = 0; m2r = 0; dst = 0; ld_data = '1;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Idle after reset: nothing bypassed (R3)
        check("R3 idle", '0);

        // Same-cycle response with a true hit (R7)
        @(posedge clk);
        is_st = 1; rw = 1; m2r = 1; dst = 3'd5; st_src = 3'd5;
        st_data = 16'h1234; ld_data = 16'hBEEF;
        #1;
        check("R7 same-cycle", 16'hBEEF);

        for (int k = 0; k < 512; k++) begin
            logic          e_st, e_rw, e_m2r;
            logic [AW-1:0] e_src, e_dst;
            logic [DW-1:0] sd, ldv, exp;
            string         req;
            e_st  = k[8];
            e_rw  = k[7];
            e_m2r = k[6];
            e_src = k[5:3];
            e_dst = k[2:0];
            sd    = DW'(16'h0100 + k);
            ldv   = ~sd;
            @(posedge clk);
            is_st = e_st; rw = e_rw; m2r = e_m2r;
            st_src = e_src; dst = e_dst; st_data = sd; ld_data = ldv;
            @(negedge clk);
            if (e_st && e_rw && e_m2r && e_dst != 0 && e_dst == e_src) begin
                req = "R1 load bypass"; exp = ldv;
            end else begin
                exp = sd;
                if (!e_st)             req = "R3 not a store";
                else if (!e_rw)        req = "R5 no reg write";
                else if (!e_m2r)       req = "R4 not a load";
                else if (e_dst == 0)   req = "R2 zero register";
                else                   req = "R6 register mismatch";
            end
            check(req, exp);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule